// File: doc/BRIEF.md
# Strided Vector Adder with Chunked Worker Contexts

This block forms Z = X + Y over three strided integer vectors that live in a word-addressed memory next to it. The caller supplies a command with three base addresses, one element stride and an element count. The block then works through the vectors in chunks of up to Q elements. For each chunk it opens a worker context. The worker first loads the chunk's X elements into a Q-entry payload. It then visits each matching Y element, adds it to the held X value and writes the sum to Z. When the count is used up, the block raises a one-cycle completion pulse.

Elements are 64-bit two's-complement integers and the add wraps modulo 2^64. The address of element i of a vector is base + i*stride, modulo 2^ADDR_W. Each chunk makes three transactions: opening the worker, carrying the filled payload, and the fetch-add-store pass. The block counts these transactions and shows the running total on a port.

The command port uses a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. A caller that holds `cmd_valid` while the block is busy is simply not accepted. The memory port has no back-pressure: a request is always served, and read data returns one cycle after the read.

Top module: `ttv_adder`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_req`, `done` and `txn_count` are 0.
- R2: For every i below the count, the word at base_z + i*stride ends up holding (X[base_x + i*stride] + Y[base_y + i*stride]) mod 2^64. No other memory word is written.
- R3: Elements are handled in chunks of Q, in index order. Every X read of a chunk comes before any Y read of that chunk. A chunk's X reads are issued in consecutive cycles.
- R4: At most one memory access is issued per cycle. `mem_we` is only high together with `mem_req`. Each Z write comes in the cycle right after the read of its matching Y element.
- R5: The final chunk holds (count mod Q) elements when that value is nonzero. A command makes exactly count X reads, count Y reads and count Z writes.
- R6: `txn_count` is cleared when a command is accepted. It equals 3*ceil(count/Q) when `done` is raised.
- R7: `done` is high for exactly one cycle. That cycle is the one right after the final Z write. For a count of 0 it is the cycle right after acceptance, and no memory access is made.
- R8: `cmd_ready` is 0 from acceptance until `done`. A `cmd_valid` asserted in that window is ignored and leaves memory contents and the access sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; command taken when both are high |
| cmd_base_x | input | ADDR_W | Word address of X element 0 |
| cmd_base_y | input | ADDR_W | Word address of Y element 0 |
| cmd_base_z | input | ADDR_W | Word address of Z element 0 |
| cmd_stride | input | ADDR_W | Distance in words between neighbouring elements |
| cmd_count | input | CNT_W | Number of elements |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data (a sum) |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |
| done | output | 1 | One-cycle completion pulse |
| txn_count | output | TXN_W | Transactions since the last accepted command |

## Verification
The hardest case to reach from the ports is a command offered while a job is still in flight, since a correct block never accepts it. The bench raises `cmd_valid` with a different Z base partway through a long job. It then checks that `cmd_ready` stays low and that no word in the decoy region changes. Partial final chunks come from counts that are not multiples of Q. These include directed counts of 1, Q and Q+1 and random counts. Every access is checked in order against an expected address and kind sequence.

// File: rtl/ttv_pkg.sv
package ttv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPAWN,
    ST_GATHER,
    ST_YRD,
    ST_ZWR
  } ttv_state_e;
endpackage

// File: rtl/ttv_payload.sv
module ttv_payload #(
  parameter int DATA_W = 64,
  parameter int Q      = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rslot,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ent [Q];

  for (genvar g = 0; g < Q; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (wslot == IDX_W'(g))) ent[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < Q; i++) begin
      if (rslot == IDX_W'(i)) rdata = ent[i];
    end
  end
endmodule

// File: rtl/ttv_txn_ctr.sv
module ttv_txn_ctr #(
  parameter int TXN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [TXN_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + TXN_W'(1);
  end
endmodule

// File: rtl/ttv_seq.sv
module ttv_seq
  import ttv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int Q      = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] base_x,
  input  logic [ADDR_W-1:0] base_y,
  input  logic [ADDR_W-1:0] base_z,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  slot,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_slot,
  output logic              txn_clr,
  output logic              txn_inc,
  output logic              done
);
  ttv_state_e        state;
  logic [ADDR_W-1:0] x_ptr, y_ptr, z_ptr, stride_r;
  logic [CNT_W-1:0]  remaining;
  logic [IDX_W-1:0]  idx, chunk_last;
  logic              accept, last_in_chunk;

  assign cmd_ready     = (state == ST_IDLE);
  assign accept        = cmd_valid && cmd_ready;
  assign last_in_chunk = (idx == chunk_last);

  assign mem_req  = (state == ST_GATHER) || (state == ST_YRD) || (state == ST_ZWR);
  assign mem_we   = (state == ST_ZWR);
  assign slot     = idx;
  assign txn_clr  = accept;
  assign txn_inc  = (state == ST_SPAWN) ||
                    ((state == ST_GATHER) && last_in_chunk) ||
                    ((state == ST_ZWR) && last_in_chunk);

  always_comb begin
    unique case (state)
      ST_GATHER: mem_addr = x_ptr;
      ST_YRD:    mem_addr = y_ptr;
      default:   mem_addr = z_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      x_ptr      <= '0;
      y_ptr      <= '0;
      z_ptr      <= '0;
      stride_r   <= '0;
      remaining  <= '0;
      idx        <= '0;
      chunk_last <= '0;
      cap_en     <= 1'b0;
      cap_slot   <= '0;
      done       <= 1'b0;
    end else begin
      done     <= 1'b0;
      cap_en   <= (state == ST_GATHER);
      cap_slot <= idx;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            x_ptr     <= base_x;
            y_ptr     <= base_y;
            z_ptr     <= base_z;
            stride_r  <= stride;
            remaining <= count;
            if (count == '0) done  <= 1'b1;
            else             state <= ST_SPAWN;
          end
        end
        ST_SPAWN: begin
          idx <= '0;
          if (remaining > CNT_W'(Q)) begin
            chunk_last <= IDX_W'(Q - 1);
            remaining  <= remaining - CNT_W'(Q);
          end else begin
            chunk_last <= IDX_W'(remaining - CNT_W'(1));
            remaining  <= '0;
          end
          state <= ST_GATHER;
        end
        ST_GATHER: begin
          x_ptr <= x_ptr + stride_r;
          if (last_in_chunk) begin
            idx   <= '0;
            state <= ST_YRD;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_YRD: begin
          y_ptr <= y_ptr + stride_r;
          state <= ST_ZWR;
        end
        ST_ZWR: begin
          z_ptr <= z_ptr + stride_r;
          if (last_in_chunk) begin
            if (remaining == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_SPAWN;
            end
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= ST_YRD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ttv_adder.sv
module ttv_adder #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int Q      = 4,
  parameter int TXN_W  = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base_x,
  input  logic [ADDR_W-1:0] cmd_base_y,
  input  logic [ADDR_W-1:0] cmd_base_z,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [TXN_W-1:0]  txn_count
);
  localparam int IDX_W = (Q > 1) ? $clog2(Q) : 1;

  logic [IDX_W-1:0]  slot, cap_slot;
  logic              cap_en, txn_clr, txn_inc;
  logic [DATA_W-1:0] held_x;

  ttv_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .Q(Q), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .base_x    (cmd_base_x),
    .base_y    (cmd_base_y),
    .base_z    (cmd_base_z),
    .stride    (cmd_stride),
    .count     (cmd_count),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .slot      (slot),
    .cap_en    (cap_en),
    .cap_slot  (cap_slot),
    .txn_clr   (txn_clr),
    .txn_inc   (txn_inc),
    .done      (done)
  );

  ttv_payload #(.DATA_W(DATA_W), .Q(Q), .IDX_W(IDX_W)) u_payload (
    .clk   (clk),
    .we    (cap_en),
    .wslot (cap_slot),
    .wdata (mem_rdata),
    .rslot (slot),
    .rdata (held_x)
  );

  ttv_txn_ctr #(.TXN_W(TXN_W)) u_txn (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (txn_clr),
    .inc   (txn_inc),
    .count (txn_count)
  );

  assign mem_wdata = held_x + mem_rdata;
endmodule

// File: rtl/ttv_adder_chk.sv
module ttv_adder_chk #(
  parameter int ADDR_W = 10,
  parameter int TXN_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [TXN_W-1:0]  txn_count
);
  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R4
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_req && mem_we) || $past(cmd_valid && cmd_ready))); // R7
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req); // R8
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R8
  AST_TXN_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && $past(cmd_ready) && !$past(cmd_valid)) |-> $stable(txn_count)); // R6
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !$isunknown(mem_addr)); // R4
endmodule

bind ttv_adder ttv_adder_chk #(.ADDR_W(ADDR_W), .TXN_W(TXN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .done      (done),
  .txn_count (txn_count)
);

// File: tb/ttv_adder_tb_top.sv
`timescale 1ns/1ps
module ttv_adder_tb_top;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 8;
  localparam int Q      = 4;
  localparam int TXN_W  = CNT_W + 2;
  localparam int MEMW   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [ADDR_W-1:0] cmd_base_x = '0, cmd_base_y = '0, cmd_base_z = '0, cmd_stride = '0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic              mem_req, mem_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [TXN_W-1:0]  txn_count;

  always #2.5 clk = ~clk;

  ttv_adder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base_x(cmd_base_x), .cmd_base_y(cmd_base_y), .cmd_base_z(cmd_base_z),
    .cmd_stride(cmd_stride), .cmd_count(cmd_count), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .txn_count(txn_count)
  );

  logic [DATA_W-1:0] mem [MEMW];
  logic [DATA_W-1:0] exp_mem [MEMW];

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    if (mem_req && mem_we)  mem[mem_addr] <= mem_wdata;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rec_kind [512];
  int rec_addr [512];
  int rec_cyc  [512];
  int rec_n = 0, done_n = 0, done_cyc = 0, acc_cyc = 0;
  int exp_kind [512];
  int exp_addr [512];

  always @(negedge clk) begin
    if (mem_req && rec_n < 512) begin
      rec_kind[rec_n] = mem_we ? 2 : ((int'(mem_addr) < 256) ? 0 : 1);
      rec_addr[rec_n] = int'(mem_addr);
      rec_cyc[rec_n]  = cyc;
      rec_n++;
    end
    if (done) begin
      done_n++;
      done_cyc = cyc;
    end
    if (cmd_valid && cmd_ready) acc_cyc = cyc;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic run_cmd(input int bx, input int by, input int bz, input int st,
                         input int cnt, input int mode, input bit poke);
    int ne, rem, i, n, bad, seq_ok, adj_ok;
    for (int a = 0; a < MEMW; a++) begin
      if (a < 512) begin
        if (mode == 1) mem[a] = (a < 256) ? (64'hFFFF_FFFF_FFFF_FFFF - 64'(a)) : 64'(a + 5);
        else           mem[a] = {$urandom, $urandom};
      end else begin
        mem[a] = 64'hA5A5_0000_0000_0000 ^ 64'(a);
      end
    end
    for (int a = 0; a < MEMW; a++) exp_mem[a] = mem[a];
    ne = 0; rem = cnt; i = 0;
    while (rem > 0) begin
      n = (rem > Q) ? Q : rem;
      for (int j = 0; j < n; j++) begin
        exp_kind[ne] = 0; exp_addr[ne] = (bx + (i + j) * st) % MEMW; ne++;
      end
      for (int j = 0; j < n; j++) begin
        int xa, ya, za;
        xa = (bx + (i + j) * st) % MEMW;
        ya = (by + (i + j) * st) % MEMW;
        za = (bz + (i + j) * st) % MEMW;
        exp_kind[ne] = 1; exp_addr[ne] = ya; ne++;
        exp_kind[ne] = 2; exp_addr[ne] = za; ne++;
        exp_mem[za] = exp_mem[xa] + exp_mem[ya];
      end
      i += n; rem -= n;
    end
    @(negedge clk);
    rec_n = 0; done_n = 0;
    cmd_valid = 1'b1;
    cmd_base_x = ADDR_W'(bx); cmd_base_y = ADDR_W'(by); cmd_base_z = ADDR_W'(bz);
    cmd_stride = ADDR_W'(st); cmd_count = CNT_W'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_base_z = ADDR_W'(900); cmd_count = CNT_W'(5); cmd_base_x = ADDR_W'(0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R8", "cmd_ready while busy", cmd_ready, 0);
      end
      cmd_valid = 1'b0;
    end
    for (int k = 0; k < 3000 && done_n == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_n == 1, "R7", "done pulses", done_n, 1);
    if (cnt == 0) begin
      chk(done_cyc == acc_cyc + 1, "R7", "done cycle after accept", done_cyc, acc_cyc + 1);
      chk(rec_n == 0, "R7", "accesses for zero count", rec_n, 0);
    end else begin
      chk(done_cyc == rec_cyc[rec_n-1] + 1, "R7", "done cycle after last write",
          done_cyc, rec_cyc[rec_n-1] + 1);
    end
    chk(rec_n == ne, "R5", "access count", rec_n, ne);
    seq_ok = 1; adj_ok = 1;
    for (int k = 0; k < ne && k < rec_n; k++) begin
      if (rec_kind[k] != exp_kind[k] || rec_addr[k] != exp_addr[k]) begin
        if (seq_ok) $display("FAIL R3 access %0d kind/addr: actual=%0d/%0d expected=%0d/%0d",
                             k, rec_kind[k], rec_addr[k], exp_kind[k], exp_addr[k]);
        seq_ok = 0;
      end
      if (k > 0 && rec_kind[k] == 2 && rec_cyc[k] != rec_cyc[k-1] + 1) adj_ok = 0;
      if (k > 0 && rec_kind[k] == 0 && rec_kind[k-1] == 0 && rec_cyc[k] != rec_cyc[k-1] + 1) adj_ok = 0;
    end
    checks++;
    if (!seq_ok) errors++;
    chk(adj_ok == 1, "R4", "Z write one cycle after Y read, X reads back to back", adj_ok, 1);
    bad = -1;
    for (int a = 0; a < MEMW; a++) if (bad < 0 && mem[a] !== exp_mem[a]) bad = a;
    if (bad >= 0)
      chk(1'b0, poke ? "R8" : "R2", $sformatf("memory word %0d", bad),
          longint'(mem[bad]), longint'(exp_mem[bad]));
    else
      chk(1'b1, "R2", "memory", 0, 0);
    chk(int'(txn_count) == 3 * ceil_div(cnt, Q), "R6", "transaction count",
        txn_count, 3 * ceil_div(cnt, Q));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(mem_req == 1'b0 && done == 1'b0, "R1", "req/done after reset", {mem_req, done}, 0);
    chk(txn_count == '0, "R1", "txn_count after reset", txn_count, 0);
    run_cmd(0, 256, 512, 1, 0, 0, 0);      // R7 zero count
    run_cmd(3, 260, 520, 2, 1, 0, 0);      // R5 single element chunk
    run_cmd(0, 256, 512, 1, Q, 0, 0);      // R3 one full chunk
    run_cmd(5, 300, 600, 3, Q + 1, 0, 0);  // R5 partial last chunk
    run_cmd(10, 270, 530, 1, 9, 1, 0);     // R2 wrap on overflow
    run_cmd(0, 256, 512, 2, 30, 0, 1);     // R8 command offered while busy
    for (int r = 0; r < 20; r++) begin
      run_cmd($urandom_range(0, 100), 256 + $urandom_range(0, 100),
              512 + $urandom_range(0, 200), $urandom_range(1, 4),
              $urandom_range(0, 35), 0, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule